// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block owns the program counter of a fetch stage for 32-bit fixed-length instructions. Each cycle it looks at the current PC and at a decoded control-transfer kind. It also looks at the instruction's index or offset field, one register operand and a pair of compare operands. From these it chooses the address of the following instruction. The choice can be the sequential address, an absolute jump inside the current 256 MB region, a PC-relative branch scaled by four, or an indirect jump to a register value. Branches come in two families: one compares two operands for equality, the other tests the sign of a single register. Link forms of the transfers also report the return address so that a register file outside the block can record it.

All results are combinational from the current PC and the inputs. The PC register takes the chosen address on every rising clock edge and loads a start address on a synchronous reset. There are no delay slots, so a taken transfer redirects the very next fetch. An indirect target whose two low bits are not zero is refused. In that case the PC holds its value and a flag is raised for the exception logic.

Top module: `pc_steer`

## Requirements
- R1: While `rst` is high at a rising edge, the PC register loads the parameter `RESET_PC` (default 0x00400000).
- R2: Kind code 0 (sequential) gives next PC = PC+4 with `taken_o` low. Kind codes 13 to 15 are unused and behave exactly like code 0.
- R3: Kind codes 1 (jump) and 2 (jump and link) give next PC = {PC[31:28], `field_i`[25:0], 2'b00}, with `taken_o` high.
- R4: A taken branch goes to PC+4 plus `field_i`[15:0] sign-extended and shifted left by two. A branch not taken goes to PC+4 with `taken_o` low. For example, offset 0xFFFE at PC 0x00400034 gives 0x00400030.
- R5: Kind code 5 is taken when `cmp_a_i` equals `cmp_b_i`. Kind code 6 is taken when they differ.
- R6: The sign-test kinds read `reg_val_i` as two's complement: code 7 is taken for <= 0, code 8 for > 0, codes 9 and 11 for < 0, and codes 10 and 12 for >= 0.
- R7: Kind codes 3 (register jump) and 4 (register jump and link) go to the full 32-bit `reg_val_i` when its two low bits are zero, with `taken_o` high.
- R8: A register jump whose `reg_val_i`[1:0] is not zero raises `misalign_o`, keeps next PC equal to PC, and holds `taken_o` and `link_we_o` low. `misalign_o` is low for every other kind.
- R9: The link kinds (2, 4, 11, 12) raise `link_we_o` with `link_val_o` = PC+4 whether or not the transfer is taken. All other kinds hold `link_we_o` low.
- R10: Out of reset, `pc_o` at each rising edge takes the `next_pc_o` value presented before that edge, and `next_pc_o` always stays a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| kind_i | input | 4 | Decoded control-transfer kind code |
| field_i | input | 26 | Jump word index; its low 16 bits are the branch offset |
| reg_val_i | input | 32 | Register operand: indirect target or sign-test value |
| cmp_a_i | input | 32 | First operand of the equality branches |
| cmp_b_i | input | 32 | Second operand of the equality branches |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address chosen for the next fetch |
| taken_o | output | 1 | Control transfer taken this cycle |
| link_we_o | output | 1 | Return address write request |
| link_val_o | output | 32 | Return address (PC+4) |
| misalign_o | output | 1 | Indirect target not word aligned |

## Verification
The PC register is the block's only state. A wrong value in it shows up at once on `pc_o`. In the same cycle it also corrupts `next_pc_o` and `link_val_o`, because both are computed from it. A faulty target or condition leaves a wrong `next_pc_o` before the edge and a wrong `pc_o` one cycle later, so every step is checked at both points. The sign-test and equality decisions are driven with operands on each side of zero and of equality. The target arithmetic is checked against an independent model, including negative offsets, wraparound and crossings of a 256 MB region.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        XK_SEQ      = 4'd0,
        XK_JMP      = 4'd1,
        XK_JMP_LNK  = 4'd2,
        XK_JREG     = 4'd3,
        XK_JREG_LNK = 4'd4,
        XK_BEQ      = 4'd5,
        XK_BNE      = 4'd6,
        XK_BLEZ     = 4'd7,
        XK_BGTZ     = 4'd8,
        XK_BLTZ     = 4'd9,
        XK_BGEZ     = 4'd10,
        XK_BLTZ_LNK = 4'd11,
        XK_BGEZ_LNK = 4'd12
    } xfer_kind_e;

    typedef enum logic [2:0] {
        CC_NEVER,
        CC_EQ,
        CC_NE,
        CC_LEZ,
        CC_GTZ,
        CC_LTZ,
        CC_GEZ
    } cond_e;

    typedef struct packed {
        logic  use_jump;
        logic  use_reg;
        logic  use_branch;
        logic  link;
        cond_e cond;
    } steer_ctl_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [3:0] kind_i,
    output steer_ctl_t ctl_o
);
    always_comb begin
        ctl_o = '{use_jump: 1'b0, use_reg: 1'b0, use_branch: 1'b0,
                  link: 1'b0, cond: CC_NEVER};
        case (kind_i)
            XK_JMP:      ctl_o.use_jump = 1'b1;
            XK_JMP_LNK:  begin ctl_o.use_jump = 1'b1; ctl_o.link = 1'b1; end
            XK_JREG:     ctl_o.use_reg = 1'b1;
            XK_JREG_LNK: begin ctl_o.use_reg = 1'b1; ctl_o.link = 1'b1; end
            XK_BEQ:      begin ctl_o.use_branch = 1'b1; ctl_o.cond = CC_EQ; end
            XK_BNE:      begin ctl_o.use_branch = 1'b1; ctl_o.cond = CC_NE; end
            XK_BLEZ:     begin ctl_o.use_branch = 1'b1; ctl_o.cond = CC_LEZ; end
            XK_BGTZ:     begin ctl_o.use_branch = 1'b1; ctl_o.cond = CC_GTZ; end
            XK_BLTZ:     begin ctl_o.use_branch = 1'b1; ctl_o.cond = CC_LTZ; end
            XK_BGEZ:     begin ctl_o.use_branch = 1'b1; ctl_o.cond = CC_GEZ; end
            XK_BLTZ_LNK: begin
                ctl_o.use_branch = 1'b1; ctl_o.cond = CC_LTZ; ctl_o.link = 1'b1;
            end
            XK_BGEZ_LNK: begin
                ctl_o.use_branch = 1'b1; ctl_o.cond = CC_GEZ; ctl_o.link = 1'b1;
            end
            default: ;  // sequential, including unused codes
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN  = 32,
    parameter int IDX_W = 26,
    parameter int OFS_W = 16
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [IDX_W-1:0] field_i,
    output logic [XLEN-1:0]  seq_o,
    output logic [XLEN-1:0]  jmp_o,
    output logic [XLEN-1:0]  br_o
);
    localparam int REGION_W = XLEN - IDX_W - 2;
    localparam int EXT_W    = XLEN - OFS_W - 2;

    logic [OFS_W-1:0] ofs;
    logic [XLEN-1:0]  ofs_scaled;

    assign ofs        = field_i[OFS_W-1:0];
    assign ofs_scaled = {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
    assign seq_o      = pc_i + XLEN'(4);
    assign br_o       = seq_o + ofs_scaled;

    generate
        if (REGION_W > 0) begin : g_region
            assign jmp_o = {pc_i[XLEN-1 -: REGION_W], field_i, 2'b00};
        end else begin : g_flat
            assign jmp_o = {field_i[XLEN-3:0], 2'b00};
        end
    endgenerate
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_e           cond_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN-1:0] rv_i,
    output logic            hit_o
);
    logic neg, zero, same;

    assign neg  = rv_i[XLEN-1];
    assign zero = (rv_i == '0);
    assign same = (a_i == b_i);

    always_comb begin
        case (cond_i)
            CC_EQ:   hit_o = same;
            CC_NE:   hit_o = !same;
            CC_LEZ:  hit_o = neg || zero;
            CC_GTZ:  hit_o = !neg && !zero;
            CC_LTZ:  hit_o = neg;
            CC_GEZ:  hit_o = !neg;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pc_steer.sv
module pc_steer
    import npc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              IDX_W    = 26,
    parameter int              OFS_W    = 16,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       kind_i,
    input  logic [IDX_W-1:0] field_i,
    input  logic [XLEN-1:0]  reg_val_i,
    input  logic [XLEN-1:0]  cmp_a_i,
    input  logic [XLEN-1:0]  cmp_b_i,
    output logic [XLEN-1:0]  pc_o,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             taken_o,
    output logic             link_we_o,
    output logic [XLEN-1:0]  link_val_o,
    output logic             misalign_o
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            taken;
        logic            link_we;
        logic            misalign;
    } step_t;

    logic [XLEN-1:0] pc_q;
    step_t           step_d;
    steer_ctl_t      ctl;
    logic [XLEN-1:0] seq_tgt, jmp_tgt, br_tgt;
    logic            br_hit;

    npc_decode u_dec (
        .kind_i (kind_i),
        .ctl_o  (ctl)
    );

    npc_target #(.XLEN(XLEN), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_tgt (
        .pc_i    (pc_q),
        .field_i (field_i),
        .seq_o   (seq_tgt),
        .jmp_o   (jmp_tgt),
        .br_o    (br_tgt)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .cond_i (ctl.cond),
        .a_i    (cmp_a_i),
        .b_i    (cmp_b_i),
        .rv_i   (reg_val_i),
        .hit_o  (br_hit)
    );

    always_comb begin
        step_d.pc       = seq_tgt;
        step_d.taken    = 1'b0;
        step_d.link_we  = ctl.link;
        step_d.misalign = 1'b0;
        if (ctl.use_jump) begin
            step_d.pc    = jmp_tgt;
            step_d.taken = 1'b1;
        end else if (ctl.use_reg) begin
            if (reg_val_i[1:0] != 2'b00) begin
                step_d.pc       = pc_q;
                step_d.link_we  = 1'b0;
                step_d.misalign = 1'b1;
            end else begin
                step_d.pc    = reg_val_i;
                step_d.taken = 1'b1;
            end
        end else if (ctl.use_branch && br_hit) begin
            step_d.pc    = br_tgt;
            step_d.taken = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= step_d.pc;
    end

    assign pc_o       = pc_q;
    assign next_pc_o  = step_d.pc;
    assign taken_o    = step_d.taken;
    assign link_we_o  = step_d.link_we;
    assign link_val_o = seq_tgt;
    assign misalign_o = step_d.misalign;
endmodule

// File: rtl/pc_steer_chk.sv
module pc_steer_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [3:0]      kind_i,
    input logic [XLEN-1:0] reg_val_i,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            taken_o,
    input logic            link_we_o,
    input logic [XLEN-1:0] link_val_o,
    input logic            misalign_o
);
    // R10
    pc_follows_next_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pc_o == $past(next_pc_o));

    // R10
    next_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        next_pc_o[1:0] == 2'b00);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 4'd0 || kind_i >= 4'd13) |-> (next_pc_o == pc_o + 4 && !taken_o));

    // R8
    misalign_hold_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (!taken_o && !link_we_o && next_pc_o == pc_o));

    // R8
    misalign_src_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> ((kind_i == 4'd3 || kind_i == 4'd4) && reg_val_i[1:0] != 2'b00));

    // R9
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> link_val_o == pc_o + 4);

    // R6
    ltz_taken_chk: assert property (@(posedge clk) disable iff (rst)
        ((kind_i == 4'd9 || kind_i == 4'd11) && reg_val_i[XLEN-1]) |-> taken_o);
endmodule

bind pc_steer pc_steer_chk #(.XLEN(XLEN)) u_steer_chk (
    .clk        (clk),
    .rst        (rst),
    .kind_i     (kind_i),
    .reg_val_i  (reg_val_i),
    .pc_o       (pc_o),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o),
    .link_we_o  (link_we_o),
    .link_val_o (link_val_o),
    .misalign_o (misalign_o)
);

// File: tb/pc_steer_bench.sv
`timescale 1ns/1ps
module pc_steer_bench;
    localparam logic [31:0] START = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  kind_i = 4'd0;
    logic [25:0] field_i = '0;
    logic [31:0] reg_val_i = '0, cmp_a_i = '0, cmp_b_i = '0;
    logic [31:0] pc_o, next_pc_o, link_val_o;
    logic        taken_o, link_we_o, misalign_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pc_steer #(.RESET_PC(START)) u_pc_steer (
        .clk(clk), .rst(rst), .kind_i(kind_i), .field_i(field_i),
        .reg_val_i(reg_val_i), .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i),
        .pc_o(pc_o), .next_pc_o(next_pc_o), .taken_o(taken_o),
        .link_we_o(link_we_o), .link_val_o(link_val_o), .misalign_o(misalign_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent reference for one step, written from the requirements.
    task automatic model(input logic [31:0] pc, input logic [3:0] k,
                         input logic [25:0] f, input logic [31:0] rv,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] npc, output logic tk,
                         output logic lw, output logic mis);
        logic signed [31:0] s;
        logic cond;
        s    = signed'(rv);
        npc  = pc + 32'd4;
        tk   = 1'b0;
        mis  = 1'b0;
        lw   = (k == 4'd2 || k == 4'd4 || k == 4'd11 || k == 4'd12);
        cond = 1'b0;
        case (k)
            4'd5:  cond = (a == b);
            4'd6:  cond = (a != b);
            4'd7:  cond = (s <= 0);
            4'd8:  cond = (s > 0);
            4'd9,  4'd11: cond = (s < 0);
            4'd10, 4'd12: cond = (s >= 0);
            default: cond = 1'b0;
        endcase
        if (k == 4'd1 || k == 4'd2) begin
            npc = (pc & 32'hF000_0000) | (32'(f) * 32'd4);
            tk  = 1'b1;
        end else if (k == 4'd3 || k == 4'd4) begin
            if (rv % 4 != 0) begin
                npc = pc; mis = 1'b1; lw = 1'b0;
            end else begin
                npc = rv; tk = 1'b1;
            end
        end else if (k >= 4'd5 && k <= 4'd12 && cond) begin
            npc = pc + 32'd4 + 32'(signed'(f[15:0]) * 4);
            tk  = 1'b1;
        end
    endtask

    // Drive one step after a falling edge, check the combinational outputs,
    // clock it in, then check the new PC.
    task automatic step(input string req, input logic [3:0] k, input logic [25:0] f,
                        input logic [31:0] rv, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] npc, pc_now;
        logic tk, lw, mis;
        @(negedge clk);
        kind_i = k; field_i = f; reg_val_i = rv; cmp_a_i = a; cmp_b_i = b;
        #1;
        pc_now = pc_o;
        model(pc_now, k, f, rv, a, b, npc, tk, lw, mis);
        check(req, "next_pc", next_pc_o, npc);
        check(req, "taken", 32'(taken_o), 32'(tk));
        check(req, "link_we", 32'(link_we_o), 32'(lw));
        if (lw) check(req, "link_val", link_val_o, pc_now + 32'd4);
        check(req, "misalign", 32'(misalign_o), 32'(mis));
        @(posedge clk); #1;
        check(req, "pc_after_edge", pc_o, npc);
    endtask

    task automatic go_to(input logic [31:0] addr);
        step("R7", 4'd3, '0, addr, '0, '0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 check("R1", "pc_in_reset", pc_o, START);
        @(negedge clk) rst = 1'b0;
        #1 check("R1", "pc_after_release", pc_o, START);
    endtask

    task automatic t_seq();
        step("R2", 4'd0, 26'h3FF_FFFF, 32'h1, 32'h5, 32'h5);
        step("R2", 4'd13, 26'h0, 32'hFFFF_FFFF, 32'h0, 32'h0);
        step("R2", 4'd15, 26'h123, 32'h3, 32'h1, 32'h1);
        go_to(32'h0FFF_FFFC);
        step("R2", 4'd0, '0, '0, '0, '0);    // crosses into region 1
    endtask

    task automatic t_jump();
        go_to(32'hF000_0010);
        step("R3", 4'd1, 26'h000_1405, '0, '0, '0);
        go_to(32'h0FFF_FFFC);
        step("R3", 4'd2, 26'h3FF_FFFF, '0, '0, '0);  // region from current PC
    endtask

    task automatic t_branch_cmp();
        go_to(32'h0040_0034);
        step("R4", 4'd5, 26'h000_FFFE, '0, 32'h7, 32'h7);  // to 0x00400030
        check("R4", "known_target", pc_o, 32'h0040_0030);
        step("R5", 4'd5, 26'h000_0010, '0, 32'h7, 32'h8);
        step("R5", 4'd6, 26'h000_0010, '0, 32'h7, 32'h8);
        step("R5", 4'd6, 26'h000_0010, '0, 32'h9, 32'h9);
        go_to(32'h0000_0000);
        step("R4", 4'd5, 26'h000_8000, '0, '0, '0);        // wraps below zero
    endtask

    task automatic t_sign();
        logic [31:0] vals [4] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000};
        go_to(32'h0010_0000);
        for (int k = 7; k <= 12; k++)
            foreach (vals[i]) step("R6", 4'(k), 26'h000_0020, vals[i], '0, '1);
    endtask

    task automatic t_jreg();
        go_to(32'h1234_5678);
        step("R7", 4'd4, '0, 32'hFFFF_FFFC, '0, '0);
        check("R7", "pc_at_reg_target", pc_o, 32'hFFFF_FFFC);
    endtask

    task automatic t_misalign();
        go_to(32'h0050_0000);
        for (int lo = 1; lo < 4; lo++) begin
            step("R8", 4'd3, '0, 32'h0060_0000 | 32'(lo), '0, '0);
            step("R8", 4'd4, '0, 32'h0070_0000 | 32'(lo), '0, '0);
        end
        check("R8", "pc_held", pc_o, 32'h0050_0000);
    endtask

    task automatic t_link();
        go_to(32'h0080_0000);
        step("R9", 4'd11, 26'h4, 32'h5, '0, '0);          // not taken, links
        step("R9", 4'd12, 26'h4, 32'h8000_0000, '0, '0);  // not taken, links
        step("R9", 4'd12, 26'h4, 32'h0, '0, '0);          // taken, links
        step("R9", 4'd5, 26'h4, '0, '0, '0);              // no link
    endtask

    task automatic t_random();
        for (int n = 0; n < 200; n++) begin
            logic [31:0] base;
            logic [3:0]  k;
            base = $urandom & 32'hFFFF_FFFC;
            if (n % 8 == 0) base = 32'h0FFF_FFF0 + ((n / 8) % 4) * 4;
            go_to(base);
            k = 4'($urandom_range(0, 15));
            step("R10", k, 26'($urandom), (n % 3 == 0) ? $urandom & 32'hFFFF_FFFC : $urandom,
                 $urandom_range(0, 3), $urandom_range(0, 3));
        end
    endtask

    initial begin
        #(8 * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_seq();
        t_jump();
        t_branch_cmp();
        t_sign();
        t_jreg();
        t_misalign();
        t_link();
        t_random();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule